// File: doc/BRIEF.md
# Packed 52-bit multiply-accumulate unit

This unit performs a lane-wise fused multiply and accumulate on vectors of 64-bit lanes. For every lane it multiplies the low 52 bits of two multiplicand operands as unsigned numbers, giving a 104-bit product. It then takes either the upper or the lower 52-bit half of that product, zero-extends it and adds it to a full 64-bit accumulator lane. A single mode input, sampled with the operands, picks the half for every lane of that operation.

Operands enter through a valid/ready handshake and results leave through another. The multiplier is pipelined over a fixed number of register stages. A full output with no ready signal stalls the whole pipeline, so results are never lost. The number of active lanes is a parameter (2 or 4). The result port always has the width of the widest configuration, and the lanes above the active count read as zero.

Top module: `mac52_vec_unit`

## Requirements
- R1: Each active lane `l` computes its result only from lane `l` of the accumulator and multiplicand inputs. `LANES` lanes are active. Lane `l` occupies bits `64*l+63 : 64*l` of every vector port.
- R2: Bits 63:52 of every multiplicand lane have no effect on any result.
- R3: When `in_hi_sel` is 1, bits 103:52 of the unsigned 104-bit product are zero-extended to 64 bits and added to the accumulator lane.
- R4: When `in_hi_sel` is 0, bits 51:0 of the product are zero-extended to 64 bits and added to the accumulator lane.
- R5: The accumulator lane is used as a full 64-bit unsigned value. The sum wraps modulo 2^64, and no carry is reported.
- R6: Result lanes at index `LANES` up to `MAX_LANES-1` are zero whenever `out_valid` is 1.
- R7: When `out_ready` stays 1, a result appears on `out_valid` exactly `STAGES` clock edges after the edge on which its operands were accepted (`in_valid` and `in_ready` both 1).
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid` and `out_data` hold their values on the next edge. No result is dropped, and results leave in the order their operands were accepted.
- R9: While `rst_n` is 0 at a rising edge, every pipeline valid flag is cleared. After such an edge, `out_valid` is 0 and `in_ready` is 1.
- R10: The mode chosen by `in_hi_sel` stays paired with the operands it was accepted with, even when operations of both modes follow each other back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand set is present |
| in_ready | output | 1 | Unit accepts an operand set this cycle |
| in_hi_sel | input | 1 | 1 selects product bits 103:52, 0 selects bits 51:0 |
| in_acc | input | 64*LANES | Accumulator lanes |
| in_mul_a | input | 64*LANES | First multiplicand lanes (low 52 bits used) |
| in_mul_b | input | 64*LANES | Second multiplicand lanes (low 52 bits used) |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64*MAX_LANES | Result lanes, inactive lanes zero |

## Verification
The bench drives both multiplicands at their 52-bit maximum in both modes. A wrong split point or an off-by-one slice shows up there as a high half that is not 2^52-2 or a low half that is not 1. An accumulator of all ones then forces a wrapping sum, and a design that keeps a carry, saturates or truncates the accumulator to 52 bits gives a wrong value. The upper multiplicand bits carry random data; a design that feeds them to the multiplier returns changed results. Back-to-back operations that alternate the mode, together with random stalls of the consumer, catch a mode bit that drifts away from its operands, a stalled result that changes or is lost, and an input that is accepted while the output is blocked.

// File: rtl/mac52_pkg.sv
// Shared constants for the packed 52-bit multiply-accumulate unit.
// Assumes lanes are 64 bits and the multiplier field is the low 52 bits.
package mac52_pkg;
    localparam int unsigned LANE_BITS = 64;
    localparam int unsigned MUL_BITS  = 52;
endpackage

// File: rtl/mac52_pipe_ctrl.sv
// Valid-flag pipeline with a global advance enable.
// The whole pipeline moves when the last stage is empty or is being taken.
// Assumes STAGES >= 1; data registers elsewhere follow the same enable.
module mac52_pipe_ctrl #(
    parameter int unsigned STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic advance,
    output logic in_ready,
    output logic out_valid
);
    logic [STAGES-1:0] vld_q;

    // Pipeline may move unless a finished result is blocked.
    assign advance   = !vld_q[STAGES-1] || out_ready;
    assign in_ready  = advance;
    assign out_valid = vld_q[STAGES-1];

    // Shift valid flags toward the output; reset clears them all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (advance) begin
            vld_q[0] <= in_valid;
            for (int s = 1; s < STAGES; s++) begin
                vld_q[s] <= vld_q[s-1];
            end
        end
    end
endmodule

// File: rtl/mac52_delay.sv
// Enable-gated delay line of STAGES registers, no reset on data.
// Assumes STAGES >= 1.
module mac52_delay #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 3
) (
    input  logic         clk,
    input  logic         advance,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe_q [STAGES];

    // Move data one stage on each advance.
    always_ff @(posedge clk) begin
        if (advance) begin
            pipe_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/mac52_lane_mul.sv
// Unsigned multiplier for one lane: low MUL_W bits of each operand.
// Upper operand bits are deliberately not used.
module mac52_lane_mul #(
    parameter int unsigned LANE_W = mac52_pkg::LANE_BITS,
    parameter int unsigned MUL_W  = mac52_pkg::MUL_BITS,
    localparam int unsigned PROD_W = 2 * MUL_W
) (
    input  logic [LANE_W-1:0] op_a,
    input  logic [LANE_W-1:0] op_b,
    output logic [PROD_W-1:0] prod
);
    logic [PROD_W-1:0] ext_a;
    logic [PROD_W-1:0] ext_b;
    logic              unused_upper;

    // Zero-extend the multiplier fields and form the full product.
    always_comb begin
        ext_a = {{(PROD_W-MUL_W){1'b0}}, op_a[MUL_W-1:0]};
        ext_b = {{(PROD_W-MUL_W){1'b0}}, op_b[MUL_W-1:0]};
        prod  = ext_a * ext_b;
    end

    assign unused_upper = ^{op_a[LANE_W-1:MUL_W], op_b[LANE_W-1:MUL_W]};
endmodule

// File: rtl/mac52_half_add.sv
// Picks one MUL_W-bit half of a lane product, zero-extends it and adds
// it to the accumulator lane modulo 2^LANE_W.
module mac52_half_add #(
    parameter int unsigned LANE_W = mac52_pkg::LANE_BITS,
    parameter int unsigned MUL_W  = mac52_pkg::MUL_BITS,
    localparam int unsigned PROD_W = 2 * MUL_W
) (
    input  logic              hi_sel,
    input  logic [LANE_W-1:0] acc,
    input  logic [PROD_W-1:0] prod,
    output logic [LANE_W-1:0] sum
);
    logic [MUL_W-1:0] half;

    // Select the half and perform the wrapping add.
    always_comb begin
        half = hi_sel ? prod[PROD_W-1:MUL_W] : prod[MUL_W-1:0];
        sum  = acc + {{(LANE_W-MUL_W){1'b0}}, half};
    end
endmodule

// File: rtl/mac52_vec_unit.sv
// Packed 52-bit multiply-accumulate unit, top level.
// LANES active lanes, each computing acc + half(a[51:0] * b[51:0]).
// Products are registered on entry and delayed STAGES-1 more stages
// together with the accumulator; the mode bit travels in its own line.
// Assumes LANES <= MAX_LANES and STAGES >= 1.
module mac52_vec_unit #(
    parameter int unsigned LANES     = 2,
    parameter int unsigned MAX_LANES = 4,
    parameter int unsigned STAGES    = 3,
    parameter int unsigned LANE_W    = mac52_pkg::LANE_BITS,
    parameter int unsigned MUL_W     = mac52_pkg::MUL_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic                        in_hi_sel,
    input  logic [LANES*LANE_W-1:0]     in_acc,
    input  logic [LANES*LANE_W-1:0]     in_mul_a,
    input  logic [LANES*LANE_W-1:0]     in_mul_b,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [MAX_LANES*LANE_W-1:0] out_data
);
    localparam int unsigned PROD_W = 2 * MUL_W;
    localparam int unsigned STG_W  = LANE_W + PROD_W;

    logic advance;
    logic hi_q;

    mac52_pipe_ctrl #(.STAGES(STAGES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .advance   (advance),
        .in_ready  (in_ready),
        .out_valid (out_valid)
    );

    mac52_delay #(.W(1), .STAGES(STAGES)) u_mode_dly (
        .clk     (clk),
        .advance (advance),
        .d       (in_hi_sel),
        .q       (hi_q)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [PROD_W-1:0] prod;
        logic [STG_W-1:0]  stg_q;

        mac52_lane_mul #(.LANE_W(LANE_W), .MUL_W(MUL_W)) u_mul (
            .op_a (in_mul_a[l*LANE_W +: LANE_W]),
            .op_b (in_mul_b[l*LANE_W +: LANE_W]),
            .prod (prod)
        );

        mac52_delay #(.W(STG_W), .STAGES(STAGES)) u_dly (
            .clk     (clk),
            .advance (advance),
            .d       ({in_acc[l*LANE_W +: LANE_W], prod}),
            .q       (stg_q)
        );

        mac52_half_add #(.LANE_W(LANE_W), .MUL_W(MUL_W)) u_add (
            .hi_sel (hi_q),
            .acc    (stg_q[STG_W-1:PROD_W]),
            .prod   (stg_q[PROD_W-1:0]),
            .sum    (out_data[l*LANE_W +: LANE_W])
        );
    end

    for (genvar u = LANES; u < MAX_LANES; u++) begin : g_idle
        assign out_data[u*LANE_W +: LANE_W] = '0;
    end
endmodule

// File: rtl/mac52_vec_unit_chk.sv
// Protocol checker for mac52_vec_unit, attached by bind.
module mac52_vec_unit_chk #(
    parameter int unsigned LANES     = 2,
    parameter int unsigned MAX_LANES = 4,
    parameter int unsigned LANE_W    = 64
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_ready,
    input logic                        out_valid,
    input logic                        out_ready,
    input logic [MAX_LANES*LANE_W-1:0] out_data
);
    // R9
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R9
    reset_ready_chk: assert property (@(posedge clk) !rst_n |=> in_ready);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    if (MAX_LANES > LANES) begin : g_upper
        // R6
        idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_data[MAX_LANES*LANE_W-1:LANES*LANE_W] == '0));
    end
endmodule

bind mac52_vec_unit mac52_vec_unit_chk #(
    .LANES(LANES), .MAX_LANES(MAX_LANES), .LANE_W(LANE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/test_mac52_vec_unit.sv
module test_mac52_vec_unit;
    localparam int LANES = 2;
    localparam int MAXL  = 4;
    localparam int STG   = 3;
    localparam int IN_W  = LANES * 64;
    localparam int OUT_W = MAXL * 64;

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0, in_hi_sel = 0, out_ready = 0;
    logic in_ready, out_valid;
    logic [IN_W-1:0]  in_acc = '0, in_mul_a = '0, in_mul_b = '0;
    logic [OUT_W-1:0] out_data;

    mac52_vec_unit #(.LANES(LANES), .MAX_LANES(MAXL), .STAGES(STG)) i_mac52_vec_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_hi_sel(in_hi_sel), .in_acc(in_acc), .in_mul_a(in_mul_a),
        .in_mul_b(in_mul_b), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    always #5 clk = ~clk;

    typedef struct { bit hi; logic [IN_W-1:0] x, a, b; } stim_t;
    stim_t             stim_q[$];
    logic [OUT_W-1:0]  exp_q[$];
    int                acc_cyc_q[$];
    int    checks = 0, failures = 0, cyc = 0;
    bit    lat_mode = 0, was_stalled = 0, finished = 0;
    logic [OUT_W-1:0] held;
    string cur_tag = "R1";

    function automatic logic [OUT_W-1:0] model(stim_t s);
        logic [OUT_W-1:0] r = '0;
        for (int l = 0; l < LANES; l++) begin
            logic [127:0] p;
            logic [51:0]  h;
            p = {76'd0, s.a[l*64 +: 52]} * {76'd0, s.b[l*64 +: 52]};
            h = s.hi ? p[103:52] : p[51:0];
            r[l*64 +: 64] = s.x[l*64 +: 64] + {12'd0, h};
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h cycle=%0d", tag, act, expv, cyc);
        end
    endtask

    function automatic logic [63:0] r64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic push(input bit hi, input logic [IN_W-1:0] x, a, b);
        stim_t s;
        s.hi = hi; s.x = x; s.a = a; s.b = b;
        stim_q.push_back(s);
    endtask

    task automatic push_rand(input bit hi);
        logic [IN_W-1:0] x, a, b;
        for (int l = 0; l < LANES; l++) begin
            x[l*64 +: 64] = r64(); a[l*64 +: 64] = r64(); b[l*64 +: 64] = r64();
        end
        push(hi, x, a, b);
    endtask

    // One cycle: drive at negedge, observe before the next posedge.
    task automatic cycle(input bit give, input bit rdy);
        if (give && stim_q.size() > 0) begin
            in_valid = 1; in_hi_sel = stim_q[0].hi; in_acc = stim_q[0].x;
            in_mul_a = stim_q[0].a; in_mul_b = stim_q[0].b;
        end else begin
            in_valid = 0;
        end
        out_ready = rdy;
        #1;
        if (was_stalled) begin
            chk(out_valid == 1'b1, "R8 valid held", 64'(out_valid), 64'd1);
            chk(out_data == held, "R8 data held", out_data[63:0], held[63:0]);
        end
        if (out_valid && !out_ready)
            chk(in_ready == 1'b0, "R8 input blocked", 64'(in_ready), 64'd0);
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected result", out_data[63:0], 64'd0);
            end else begin
                logic [OUT_W-1:0] e;
                int ac;
                e = exp_q.pop_front();
                ac = acc_cyc_q.pop_front();
                for (int l = 0; l < LANES; l++)
                    chk(out_data[l*64 +: 64] == e[l*64 +: 64], cur_tag,
                        out_data[l*64 +: 64], e[l*64 +: 64]);
                for (int l = LANES; l < MAXL; l++)
                    chk(out_data[l*64 +: 64] == 64'd0, "R6 idle lane",
                        out_data[l*64 +: 64], 64'd0);
                if (lat_mode)
                    chk(cyc - ac == STG, "R7 latency", 64'(cyc - ac), 64'(STG));
            end
        end
        was_stalled = out_valid && !out_ready;
        held = out_data;
        if (in_valid && in_ready) begin
            exp_q.push_back(model(stim_q[0]));
            acc_cyc_q.push_back(cyc);
            void'(stim_q.pop_front());
        end
        @(posedge clk); cyc++; @(negedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && (stim_q.size() > 0 || exp_q.size() > 0); i++)
            cycle(1, 1);
        chk(exp_q.size() == 0, "R8 all results out", 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] ones = '1;
        logic [51:0] m52  = '1;
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(out_valid == 0, "R9 reset valid", 64'(out_valid), 64'd0);
        chk(in_ready == 1, "R9 reset ready", 64'(in_ready), 64'd1);
        @(negedge clk);

        lat_mode = 1;
        cur_tag = "R3 high half";
        push(1, '0, {2{12'd0, m52}}, {2{12'd0, m52}});
        push(1, {64'd5, 64'd7}, {64'd3, 64'h0008_0000_0000_0000}, {64'd9, 64'h0000_0000_0000_0002});
        drain();
        cur_tag = "R4 low half";
        push(0, '0, {2{12'd0, m52}}, {2{12'd0, m52}});
        push(0, {64'd1, 64'd2}, {64'd3, 64'd4}, {64'd5, 64'd6});
        drain();
        cur_tag = "R5 wrap";
        push(0, {2{ones}}, {2{12'd0, m52}}, {2{12'd0, m52}});
        push(1, {2{ones}}, {2{12'd0, m52}}, {2{12'd0, m52}});
        drain();
        cur_tag = "R2 upper bits ignored";
        push(0, {64'd11, 64'd22}, {12'hfff, 52'd3, 12'ha5a, 52'd4}, {12'h123, 52'd5, 12'hfff, 52'd6});
        push(1, {64'd11, 64'd22}, {12'hfff, m52, 12'h800, m52}, {12'h001, m52, 12'hfff, m52});
        for (int i = 0; i < 10; i++) push_rand(i[0]);
        drain();
        cur_tag = "R10 mode pairing";
        for (int i = 0; i < 12; i++) begin
            push(i[0], {2{64'd100}}, {2{12'd0, m52}}, {2{12'd0, m52}});
        end
        drain();
        cur_tag = "R1 lane independence";
        for (int i = 0; i < 40; i++) push_rand($urandom() % 2 == 1);
        drain();

        lat_mode = 0;
        cur_tag = "R8 random stalls";
        for (int i = 0; i < 300; i++) push_rand($urandom() % 2 == 1);
        for (int i = 0; i < 3000 && (stim_q.size() > 0 || exp_q.size() > 0); i++)
            cycle($urandom() % 4 != 0, $urandom() % 3 != 0);
        drain();

        cur_tag = "R9 reset flush";
        for (int i = 0; i < 6; i++) push_rand(1);
        for (int i = 0; i < 6; i++) cycle(1, 0);
        rst_n = 0; in_valid = 0; was_stalled = 0;
        @(posedge clk); cyc++; @(negedge clk);
        #1;
        chk(out_valid == 0, "R9 flush valid", 64'(out_valid), 64'd0);
        chk(in_ready == 1, "R9 flush ready", 64'(in_ready), 64'd1);
        stim_q.delete(); exp_q.delete(); acc_cyc_q.delete();
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        lat_mode = 1;
        cur_tag = "R1 after reset";
        for (int i = 0; i < 20; i++) push_rand($urandom() % 2 == 1);
        drain();

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule